// File: doc/BRIEF.md
# Double-Buffered Bulk Endpoint Flow Controller

This block governs one bulk endpoint that moves data in a single direction through a pair of packet buffers. The bus-side engine fills or drains one buffer while application software works on the other. Ownership is tracked by two one-bit flags. The hardware flag names the buffer the bus side is using. The software flag names the buffer software holds. When the two flags differ, the bus side has a buffer and tokens are answered with ACK (or data). When the flags are equal, both sides would touch the same buffer, and tokens are answered with NAK until software hands its buffer back.

The flags sit in a 16-bit control word at bit positions 6 and 14. Which flag lives where depends on the endpoint direction. The word is updated with toggle-on-one writes. After each successful transaction the hardware flag flips, so the endpoint falls back to NAK only on a real collision and not after every packet. A one-cycle completion pulse reports the direction and the buffer index that was just used. An endpoint that needs double buffering in both directions is built from two instances.

Top module: `dbuf_bulk_ep`

## Requirements
- R1: After synchronous reset, both flags are 0, `reg_rd_data` is 0, and `rsp_valid`, `rsp_ack`, `desc_valid`, `desc_sel` and `done_pulse` are all 0.
- R2: With `dir_tx`=1, the hardware flag is control bit 6 and the software flag is control bit 14, both in `reg_rd_data` and for writes. All other read bits are 0.
- R3: With `dir_tx`=0, the hardware flag is control bit 14 and the software flag is control bit 6, both in `reg_rd_data` and for writes.
- R4: On a cycle with `reg_wr_en`=1, a 1 written at a flag's bit position toggles that flag. A 0 at that position leaves the flag unchanged. Without `reg_wr_en`, neither flag changes except as R7 states.
- R5: A `tok_valid` cycle while the flags differ gives, on the next cycle, `rsp_valid`=1, `rsp_ack`=1 (ACK) and `desc_valid`=1. In that response, `desc_sel` equals the hardware flag's value when the token arrived: 0 selects address/count pair 0 and 1 selects pair 1.
- R6: A `tok_valid` cycle while the flags are equal gives, on the next cycle, `rsp_valid`=1, `rsp_ack`=0 (NAK), `desc_valid`=0 and `desc_sel`=0.
- R7: An `xfer_done` cycle while the flags differ toggles the hardware flag at the next edge. The next token is then NAKed only if the new value equals the software flag.
- R8: An accepted `xfer_done` produces, on the next cycle only, `done_pulse`=1. On that cycle `done_dir_tx` equals `dir_tx` and `done_idx` equals the hardware flag's value before it toggled.
- R9: An `xfer_done` while the flags are equal is ignored: the hardware flag does not change and `done_pulse` stays 0.
- R10: When a register write toggling the hardware flag and an accepted `xfer_done` happen in the same cycle, both toggles apply, so the hardware flag ends unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_tx | input | 1 | 1 = transmit (IN) endpoint, 0 = receive (OUT) endpoint |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wr_data | input | 16 | Control word write data, toggle-on-one at flag positions |
| reg_rd_data | output | 16 | Control word view of the two flags |
| tok_valid | input | 1 | Token arrived for this endpoint |
| xfer_done | input | 1 | Bus engine finished a transaction successfully |
| rsp_valid | output | 1 | Handshake decision valid |
| rsp_ack | output | 1 | 1 = ACK/data, 0 = NAK |
| desc_valid | output | 1 | `desc_sel` names a usable descriptor pair |
| desc_sel | output | 1 | Address/count descriptor pair index for the bus side |
| done_pulse | output | 1 | One-cycle transaction-complete pulse |
| done_dir_tx | output | 1 | Direction reported with the pulse |
| done_idx | output | 1 | Buffer index just used |

## Verification
The bench sweeps both directions through all four flag combinations and checks the response and descriptor index for each. A design with the flags' roles swapped would ACK with the wrong pair or NAK the wrong state. It then walks a run of transactions into a collision, to catch a design that NAKs after every packet or never NAKs. It checks that a completion during a collision leaves the hardware flag alone; a design that accepts it would desynchronise the buffer ownership. Finally it collides a register toggle with a completion in the same cycle, where a design giving one source priority over the other would drop a toggle.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  localparam int CTRL_W   = 16;
  localparam int TOG6_POS = 6;
  localparam int TOG14_POS = 14;

  typedef struct packed {
    logic hw;
    logic sw;
  } own_flags_t;
endpackage

// File: rtl/dbuf_bit_map.sv
module dbuf_bit_map #(
  parameter int REG_W  = 16,
  parameter int LO_POS = 6,
  parameter int HI_POS = 14
) (
  input  logic             dir_tx,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             hw_flag,
  input  logic             sw_flag,
  output logic             hw_tgl,
  output logic             sw_tgl,
  output logic [REG_W-1:0] rd_data
);
  localparam int HW_TX = LO_POS;
  localparam int SW_TX = HI_POS;

  logic lo_bit, hi_bit;

  always_comb begin
    lo_bit = wr_en & wr_data[LO_POS];
    hi_bit = wr_en & wr_data[HI_POS];
    hw_tgl = dir_tx ? lo_bit : hi_bit;
    sw_tgl = dir_tx ? hi_bit : lo_bit;
    rd_data = '0;
    rd_data[HW_TX] = dir_tx ? hw_flag : sw_flag;
    rd_data[SW_TX] = dir_tx ? sw_flag : hw_flag;
  end
endmodule

// File: rtl/dbuf_owner.sv
module dbuf_owner (
  input  logic clk,
  input  logic rst,
  input  logic hw_tgl,
  input  logic sw_tgl,
  input  logic xfer_done,
  output logic hw_flag,
  output logic sw_flag,
  output logic done_ok,
  output logic used_idx
);
  logic conflict;

  always_comb begin
    conflict = (hw_flag == sw_flag);
    done_ok  = xfer_done & ~conflict;
    used_idx = hw_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hw_flag <= 1'b0;
      sw_flag <= 1'b0;
    end else begin
      hw_flag <= hw_flag ^ hw_tgl ^ done_ok;
      sw_flag <= sw_flag ^ sw_tgl;
    end
  end

  assert_done_toggles_R7: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && (hw_flag != sw_flag) && !hw_tgl) |=> (hw_flag != $past(hw_flag)));

  assert_conflict_holds_hw_R9: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && (hw_flag == sw_flag) && !hw_tgl) |=> $stable(hw_flag));

  assert_sw_only_by_write_R4: assert property (@(posedge clk) disable iff (rst)
    !sw_tgl |=> $stable(sw_flag));
endmodule

// File: rtl/dbuf_resp.sv
module dbuf_resp (
  input  logic clk,
  input  logic rst,
  input  logic tok_valid,
  input  logic hw_flag,
  input  logic sw_flag,
  input  logic done_ok,
  input  logic used_idx,
  input  logic dir_tx,
  output logic rsp_valid,
  output logic rsp_ack,
  output logic desc_valid,
  output logic desc_sel,
  output logic done_pulse,
  output logic done_dir_tx,
  output logic done_idx
);
  logic owns;

  always_comb owns = (hw_flag != sw_flag);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_ack     <= 1'b0;
      desc_valid  <= 1'b0;
      desc_sel    <= 1'b0;
      done_pulse  <= 1'b0;
      done_dir_tx <= 1'b0;
      done_idx    <= 1'b0;
    end else begin
      rsp_valid  <= tok_valid;
      rsp_ack    <= tok_valid & owns;
      desc_valid <= tok_valid & owns;
      desc_sel   <= tok_valid & owns & hw_flag;
      done_pulse <= done_ok;
      if (done_ok) begin
        done_dir_tx <= dir_tx;
        done_idx    <= used_idx;
      end
    end
  end

  assert_rsp_follows_tok_R5: assert property (@(posedge clk) disable iff (rst)
    tok_valid |=> rsp_valid);

  assert_nak_on_conflict_R6: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && (hw_flag == sw_flag)) |=> (rsp_valid && !rsp_ack && !desc_valid));

  assert_ack_has_desc_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ack) |-> desc_valid);

  assert_pulse_after_done_R8: assert property (@(posedge clk) disable iff (rst)
    done_ok |=> done_pulse);
endmodule

// File: rtl/dbuf_bulk_ep.sv
module dbuf_bulk_ep
  import dbuf_pkg::*;
#(
  parameter int REG_W  = CTRL_W,
  parameter int LO_POS = TOG6_POS,
  parameter int HI_POS = TOG14_POS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_tx,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  output logic [REG_W-1:0] reg_rd_data,
  input  logic             tok_valid,
  input  logic             xfer_done,
  output logic             rsp_valid,
  output logic             rsp_ack,
  output logic             desc_valid,
  output logic             desc_sel,
  output logic             done_pulse,
  output logic             done_dir_tx,
  output logic             done_idx
);
  own_flags_t flags;
  logic hw_tgl, sw_tgl, done_ok, used_idx;

  dbuf_bit_map #(.REG_W(REG_W), .LO_POS(LO_POS), .HI_POS(HI_POS)) u_map (
    .dir_tx (dir_tx),
    .wr_en  (reg_wr_en),
    .wr_data(reg_wr_data),
    .hw_flag(flags.hw),
    .sw_flag(flags.sw),
    .hw_tgl (hw_tgl),
    .sw_tgl (sw_tgl),
    .rd_data(reg_rd_data)
  );

  dbuf_owner u_own (
    .clk      (clk),
    .rst      (rst),
    .hw_tgl   (hw_tgl),
    .sw_tgl   (sw_tgl),
    .xfer_done(xfer_done),
    .hw_flag  (flags.hw),
    .sw_flag  (flags.sw),
    .done_ok  (done_ok),
    .used_idx (used_idx)
  );

  dbuf_resp u_rsp (
    .clk        (clk),
    .rst        (rst),
    .tok_valid  (tok_valid),
    .hw_flag    (flags.hw),
    .sw_flag    (flags.sw),
    .done_ok    (done_ok),
    .used_idx   (used_idx),
    .dir_tx     (dir_tx),
    .rsp_valid  (rsp_valid),
    .rsp_ack    (rsp_ack),
    .desc_valid (desc_valid),
    .desc_sel   (desc_sel),
    .done_pulse (done_pulse),
    .done_dir_tx(done_dir_tx),
    .done_idx   (done_idx)
  );
endmodule

// File: tb/dbuf_bulk_ep_bench.sv
module dbuf_bulk_ep_bench;
  logic clk = 0;
  logic rst = 1;
  logic dir_tx = 0;
  logic reg_wr_en = 0;
  logic [15:0] reg_wr_data = '0;
  logic [15:0] reg_rd_data;
  logic tok_valid = 0, xfer_done = 0;
  logic rsp_valid, rsp_ack, desc_valid, desc_sel, done_pulse, done_dir_tx, done_idx;

  int n_chk = 0, n_fail = 0;
  logic hw_m, sw_m;

  always #10 clk = ~clk;

  dbuf_bulk_ep u_dbuf_bulk_ep (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input logic d, input logic hw, input logic sw);
    logic [15:0] w;
    w = '0;
    w[6]  = d ? hw : sw;
    w[14] = d ? sw : hw;
    return w;
  endfunction

  task automatic step(input bit tok, input bit done, input bit wen, input bit thw, input bit tsw);
    bit accept, e_ack, e_sel, e_idx;
    string ftag;
    @(negedge clk);
    tok_valid = tok;
    xfer_done = done;
    reg_wr_en = wen;
    reg_wr_data = word_of(dir_tx, thw, tsw) | 16'hBFBF & 16'h0000;
    if (wen) reg_wr_data = word_of(dir_tx, thw, tsw) | 16'h3A05;
    accept = done && (hw_m != sw_m);
    e_ack  = tok && (hw_m != sw_m);
    e_sel  = e_ack && hw_m;
    e_idx  = hw_m;
    if (done && !accept) ftag = "R9";
    else if (wen && accept) ftag = "R10";
    else if (accept) ftag = "R7";
    else ftag = "R4";
    hw_m = hw_m ^ (wen & thw) ^ accept;
    sw_m = sw_m ^ (wen & tsw);
    @(negedge clk);
    tok_valid = 0; xfer_done = 0; reg_wr_en = 0; reg_wr_data = '0;
    check(reg_rd_data == word_of(dir_tx, hw_m, sw_m), ftag, reg_rd_data, word_of(dir_tx, hw_m, sw_m));
    check(reg_rd_data == word_of(dir_tx, hw_m, sw_m), dir_tx ? "R2" : "R3",
          reg_rd_data, word_of(dir_tx, hw_m, sw_m));
    if (tok) begin
      check(rsp_valid && rsp_ack == e_ack && desc_valid == e_ack && desc_sel == e_sel,
            e_ack ? "R5" : "R6", {rsp_valid, rsp_ack, desc_valid, desc_sel},
            {1'b1, e_ack, e_ack, e_sel});
    end else begin
      check(!rsp_valid, "R5", rsp_valid, 0);
    end
    check(done_pulse == accept, accept ? "R8" : "R9", done_pulse, accept);
    if (accept)
      check(done_dir_tx == dir_tx && done_idx == e_idx, "R8", {done_dir_tx, done_idx}, {dir_tx, e_idx});
    @(negedge clk);
    check(!done_pulse && !rsp_valid, "R8", {done_pulse, rsp_valid}, 0);
  endtask

  initial begin
    for (int d = 0; d < 2; d++) begin
      rst = 1;
      dir_tx = d[0];
      repeat (2) @(negedge clk);
      rst = 0;
      hw_m = 0; sw_m = 0;
      check(reg_rd_data == 0 && !rsp_valid && !rsp_ack && !desc_valid && !desc_sel && !done_pulse,
            "R1", reg_rd_data, 0);
      for (int c = 0; c < 4; c++) begin
        step(0, 0, 1, c[0] ^ hw_m, c[1] ^ sw_m);
        step(1, 0, 0, 0, 0);
      end
      step(0, 0, 1, 0, 0);
      step(0, 0, 1, hw_m, ~sw_m);
      step(1, 0, 0, 0, 0);
      step(0, 1, 0, 0, 0);
      step(1, 0, 0, 0, 0);
      step(0, 1, 0, 0, 0);
      step(1, 1, 0, 0, 0);
      step(0, 0, 1, 0, 1);
      step(1, 1, 0, 0, 0);
      step(0, 0, 1, 0, 1);
      step(1, 1, 1, 1, 0);
      step(1, 0, 0, 0, 0);
      step(0, 1, 1, 0, 1);
      step(1, 0, 0, 0, 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule